// File: doc/BRIEF.md
# Tag Store with Compare Match

This block is a small synchronous tag memory with a built-in equality comparator, meant to sit beside a cache data array. On every rising clock edge it decodes one of four operations from the select, write and data-enable inputs: read, write, compare or fill. A compare is a read in which the caller also loads a probe tag into a holding register; the stored word at the addressed location is then checked against that probe and a match flag is produced. A later fill operation writes the held probe back into the memory, so a miss can be repaired without driving the tag again.

The stored data and the match flag leave the block either straight from the read stage or through one more register, as chosen by a mode input. Two asynchronous enables (one for data, one for the match flag) decide whether each output is being driven; a floating output is shown as a low valid bit. When no read-type operation is in progress, the match flag rests high.

Top module: `tag_cmp_unit`

## Requirements
- R1: The block is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at a rising edge; in any other edge the memory and the probe register are left unchanged and no read stage is started.
- R2: A selected edge with `we_n`=0 and `cap_en`=1 stores `din` at `addr`.
- R3: The probe register loads `din` only at a selected edge with `cap_en`=1 (write or compare); with `cap_en`=0 it holds its value.
- R4: A selected edge with `we_n`=0 and `cap_en`=0 (fill) stores the probe register's value at `addr`; `din` has no effect on the stored word.
- R5: A selected edge with `we_n`=1 (read, or compare when `cap_en`=1) starts a read stage; `dout` then shows the word at that address and `dout_vld` is 1 whenever `oe_n`=0 while the stage is shown.
- R6: While a read stage is shown, `match` is 1 exactly when the addressed stored word equals the probe register's value.
- R7: With `pipe_mode`=0 the data and match of a read stage are shown in the clock period right after its sampling edge.
- R8: With `pipe_mode`=1 they are shown one clock period later, taken from the flow-through values at the next edge.
- R9: When no read stage is shown, `match` is 1 and `dout_vld` is 0.
- R10: `match_vld` equals the inverse of `moe_n` at all times, with no clock involved.
- R11: While `rst_n`=0 the read stages clear, the probe register clears to zero and the registered match rests at 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Tag location |
| din | input | TAG_W | Tag to write or probe tag to compare |
| cs1_n | input | 1 | Select, active low |
| cs2 | input | 1 | Select, active high |
| cs3_n | input | 1 | Select, active low |
| we_n | input | 1 | Write request, active low |
| cap_en | input | 1 | Data-enable: allows `din` into the probe register and marks write vs fill |
| oe_n | input | 1 | Asynchronous data output enable, active low |
| moe_n | input | 1 | Asynchronous match output enable, active low |
| pipe_mode | input | 1 | 1 = registered outputs, 0 = flow-through |
| dout | output | TAG_W | Stored word of the shown read stage |
| dout_vld | output | 1 | Data is driven and belongs to a read stage |
| match | output | 1 | Compare result, 1 when idle |
| match_vld | output | 1 | Match flag is driven |

## Verification
A read or compare sampled at edge k shows its data and match in the period after edge k in flow-through mode and in the period after edge k+1 in registered mode; writes and fills sampled at edge k are visible to any read sampled at edge k+1 or later. The bench drives inputs on the falling edge, advances its own reference array, probe register and one-deep output register model at the rising edge in the same order the rules give, and compares at the following falling edge, so each result is checked in exactly the period it is due. The two output enables are combinational, so their effect is checked in the same period as they are driven.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_FILL  = 2'd3
  } tcm_op_e;

  // Three-input select: two active-low, one active-high.
  function automatic logic chip_sel(input logic s1_n, input logic s2, input logic s3_n);
    return !s1_n && s2 && !s3_n;
  endfunction

  function automatic tcm_op_e decode_op(input logic sel, input logic we_n, input logic cap_en);
    if (!sel)  return OP_IDLE;
    if (we_n)  return OP_READ;
    if (cap_en) return OP_WRITE;
    return OP_FILL;
  endfunction

  // Equality on zero-extended operands (tag widths up to 64 bits).
  function automatic logic tag_hit(input logic [63:0] stored, input logic [63:0] probe);
    return stored == probe;
  endfunction

endpackage

// File: rtl/tcm_tag_array.sv
module tcm_tag_array #(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 18
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [TAG_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [TAG_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/tcm_probe_reg.sv
module tcm_probe_reg #(
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] din,
  output logic [TAG_W-1:0] probe
);
  always_ff @(posedge clk) begin
    if (!rst_n)    probe <= '0;
    else if (load) probe <= din;
  end
endmodule

// File: rtl/tcm_out_stage.sv
module tcm_out_stage #(
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             ft_vld,
  input  logic [TAG_W-1:0] ft_data,
  input  logic             ft_match,
  input  logic             oe_n,
  input  logic             moe_n,
  output logic [TAG_W-1:0] dout,
  output logic             dout_vld,
  output logic             match,
  output logic             match_vld
);
  logic             pv_q;
  logic [TAG_W-1:0] pd_q;
  logic             pm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pd_q <= '0;
      pm_q <= 1'b1;
    end else begin
      pv_q <= ft_vld;
      pd_q <= ft_data;
      pm_q <= ft_match;
    end
  end

  logic shown_vld;
  assign shown_vld = pipe_mode ? pv_q : ft_vld;
  assign dout      = pipe_mode ? pd_q : ft_data;
  assign dout_vld  = shown_vld && !oe_n;
  assign match     = pipe_mode ? pm_q : ft_match;
  assign match_vld = !moe_n;
endmodule

// File: rtl/tag_cmp_unit.sv
module tag_cmp_unit #(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  din,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              we_n,
  input  logic              cap_en,
  input  logic              oe_n,
  input  logic              moe_n,
  input  logic              pipe_mode,
  output logic [TAG_W-1:0]  dout,
  output logic              dout_vld,
  output logic              match,
  output logic              match_vld
);
  import tcm_pkg::*;

  // Named internal events, used by the bound checker.
  logic             sel_w;
  tcm_op_e          op_w;
  logic             mem_we_w;
  logic             probe_load_w;
  logic [TAG_W-1:0] wdata_w;
  logic [TAG_W-1:0] probe_w;
  logic [TAG_W-1:0] rdata_w;
  logic             rd_vld_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic             ft_match_w;

  assign sel_w        = chip_sel(cs1_n, cs2, cs3_n);
  assign op_w         = decode_op(sel_w, we_n, cap_en);
  assign mem_we_w     = (op_w == OP_WRITE) || (op_w == OP_FILL);
  assign probe_load_w = sel_w && cap_en;
  assign wdata_w      = (op_w == OP_FILL) ? probe_w : din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_vld_q  <= (op_w == OP_READ);
      if (op_w == OP_READ) rd_addr_q <= addr;
    end
  end

  tcm_tag_array #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_array (
    .clk   (clk),
    .wr_en (mem_we_w),
    .waddr (addr),
    .wdata (wdata_w),
    .raddr (rd_addr_q),
    .rdata (rdata_w)
  );

  tcm_probe_reg #(.TAG_W(TAG_W)) u_probe (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (probe_load_w),
    .din   (din),
    .probe (probe_w)
  );

  assign ft_match_w = rd_vld_q ? tag_hit(64'(rdata_w), 64'(probe_w)) : 1'b1;

  tcm_out_stage #(.TAG_W(TAG_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .ft_vld    (rd_vld_q),
    .ft_data   (rdata_w),
    .ft_match  (ft_match_w),
    .oe_n      (oe_n),
    .moe_n     (moe_n),
    .dout      (dout),
    .dout_vld  (dout_vld),
    .match     (match),
    .match_vld (match_vld)
  );
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
  parameter int TAG_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             we_n,
  input logic             cap_en,
  input logic             rd_vld,
  input logic [TAG_W-1:0] probe,
  input logic             ft_match,
  input logic             pipe_mode,
  input logic             match,
  input logic             dout_vld
);
  // R1: a deselected edge starts no read stage
  p_no_stage_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !rd_vld);

  // R3: probe register holds when data-enable is low
  p_probe_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(probe));

  // R5: a selected read-type edge starts a read stage
  p_read_starts_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we_n) |=> rd_vld);

  // R8: registered match equals the flow-through match of the previous period
  p_pipe_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(rst_n)) |-> match == $past(ft_match));

  // R9: idle flow-through output rests high and undriven data
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !rd_vld) |-> (match && !dout_vld));

  // R11: reset clears the read stage
  p_reset_clears_r11: assert property (@(posedge clk)
    !rst_n |=> !rd_vld);
endmodule

bind tag_cmp_unit tcm_checker #(.TAG_W(TAG_W)) u_tcm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel_w),
  .we_n      (we_n),
  .cap_en    (cap_en),
  .rd_vld    (rd_vld_q),
  .probe     (probe_w),
  .ft_match  (ft_match_w),
  .pipe_mode (pipe_mode),
  .match     (match),
  .dout_vld  (dout_vld)
);

// File: tb/tag_cmp_unit_tb_top.sv
module tag_cmp_unit_tb_top;
  localparam int AW    = 6;
  localparam int TW    = 18;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [TW-1:0] din;
  logic          cs1_n, cs2, cs3_n, we_n, cap_en, oe_n, moe_n, pipe_mode;
  logic [TW-1:0] dout;
  logic          dout_vld, match, match_vld;

  always #2 clk = ~clk;

  tag_cmp_unit #(.ADDR_W(AW), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .we_n(we_n), .cap_en(cap_en),
    .oe_n(oe_n), .moe_n(moe_n), .pipe_mode(pipe_mode),
    .dout(dout), .dout_vld(dout_vld), .match(match), .match_vld(match_vld)
  );

  int checks = 0;
  int failures = 0;
  string phase = "";

  // reference state
  logic [TW-1:0] m_mem [DEPTH];
  logic [TW-1:0] m_probe;
  logic          m_vld;
  logic [AW-1:0] m_addr;
  logic          m_pvld;
  logic [TW-1:0] m_pdata;
  logic          m_pmatch;

  function automatic logic selected(logic a_n, logic b, logic c_n);
    return (a_n == 1'b0) && (b == 1'b1) && (c_n == 1'b0);
  endfunction

  function automatic logic exp_ft_match();
    if (!m_vld) return 1'b1;
    return (m_mem[m_addr] === m_probe) ? 1'b1 : 1'b0;
  endfunction

  task automatic check(string tag, string what, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", tag, phase, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic sv, em;
    logic [TW-1:0] ed;
    sv = pipe_mode ? m_pvld : m_vld;
    ed = pipe_mode ? m_pdata : m_mem[m_addr];
    em = pipe_mode ? m_pmatch : exp_ft_match();
    check("R10", "match_vld", TW'(match_vld), TW'(!moe_n));
    check(sv ? "R5" : "R9", "dout_vld", TW'(dout_vld), TW'(sv && !oe_n));
    if (sv) check(pipe_mode ? "R5 R8" : "R5 R7", "dout", dout, ed);
    if (sv) check(pipe_mode ? "R6 R8" : "R6 R7", "match", TW'(match), TW'(em));
    else    check("R9", "idle match", TW'(match), TW'(em));
  endtask

  // One clock: inputs applied now (falling edge), model stepped at the rising edge,
  // outputs compared at the next falling edge.
  task automatic cyc(logic s1n, logic s2, logic s3n, logic wn, logic ce,
                     logic [AW-1:0] a, logic [TW-1:0] d, logic on, logic mn, logic pm);
    logic sel;
    cs1_n = s1n; cs2 = s2; cs3_n = s3n; we_n = wn; cap_en = ce;
    addr = a; din = d; oe_n = on; moe_n = mn; pipe_mode = pm;
    @(posedge clk);
    sel = selected(s1n, s2, s3n);
    m_pvld   = m_vld;
    m_pdata  = m_mem[m_addr];
    m_pmatch = exp_ft_match();
    if (sel && !wn &&  ce) m_mem[a] = d;
    if (sel && !wn && !ce) m_mem[a] = m_probe;
    if (sel && ce) m_probe = d;
    m_vld = sel && wn;
    if (sel && wn) m_addr = a;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic op(logic wn, logic ce, logic [AW-1:0] a, logic [TW-1:0] d, logic pm);
    cyc(1'b0, 1'b1, 1'b0, wn, ce, a, d, 1'b0, 1'b0, pm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; we_n = 1'b1; cap_en = 1'b0;
    addr = '0; din = '0; oe_n = 1'b0; moe_n = 1'b0; pipe_mode = 1'b1;
    m_probe = '0; m_vld = 1'b0; m_addr = '0; m_pvld = 1'b0; m_pdata = '0; m_pmatch = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    phase = "R11 reset";
    check("R11", "match", TW'(match), TW'(1'b1));
    check("R11", "dout_vld", TW'(dout_vld), '0);
    rst_n = 1'b1;

    // R2: fill the whole array with known words
    phase = "R2 init";
    for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, AW'(i), TW'(i * 37 + 5), 1'b0);
    for (int i = 0; i < DEPTH; i++) m_mem[i] = TW'(i * 37 + 5);
    op(1'b1, 1'b0, AW'(3), '0, 1'b0);

    // R6 R7: flow-through compare hit then miss
    phase = "R6 R7 ft hit/miss";
    op(1'b1, 1'b1, AW'(4), TW'(4 * 37 + 5), 1'b0);
    op(1'b1, 1'b1, AW'(4), TW'(12345), 1'b0);
    // R6 R8: registered compare hit then miss, then idle drains
    phase = "R6 R8 pipe hit/miss";
    op(1'b1, 1'b1, AW'(9), TW'(9 * 37 + 5), 1'b1);
    op(1'b1, 1'b1, AW'(9), TW'(777), 1'b1);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);

    // R4: fill writes the held probe (777), din is a decoy
    phase = "R4 fill";
    op(1'b0, 1'b0, AW'(20), TW'(18'h3ffff), 1'b0);
    op(1'b1, 1'b0, AW'(20), '0, 1'b0);
    check("R4", "filled word", dout, TW'(777));

    // R3: compare with cap_en low keeps the old probe
    phase = "R3 hold";
    op(1'b1, 1'b0, AW'(20), TW'(55), 1'b0);
    check("R3", "match on held probe", TW'(match), TW'(1'b1));

    // R1: each partial select blocks a write
    phase = "R1 deselect";
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, AW'(30), TW'(1), 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, AW'(30), TW'(2), 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, AW'(30), TW'(3), 1'b0, 1'b0, 1'b0);
    op(1'b1, 1'b0, AW'(30), '0, 1'b0);
    check("R1", "unchanged word", dout, TW'(30 * 37 + 5));

    // R10 R5: enables released float the outputs
    phase = "R10 enables";
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(5), '0, 1'b1, 1'b1, 1'b0);

    // Random mix on a small address window so hits and fills recur
    phase = "random";
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic [TW-1:0] d;
      int r;
      a = AW'($urandom_range(0, 7));
      r = $urandom_range(0, 9);
      d = (r < 5) ? m_mem[a] : TW'($urandom);
      cyc(($urandom_range(0, 7) == 0), ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 2) != 0), ($urandom_range(0, 1) == 1), a, d,
          ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
          ((n / 200) % 2 == 1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule